// File: doc/BRIEF.md
# Timer compare output unit

This block watches one of two free-running synchronous 16-bit timers and compares the selected timer value against a programmable 16-bit compare register. When the two values become equal, the block performs the action chosen by a 4-bit mode field. The action can drive an output latch high, drive it low, toggle it, raise only the interrupt flag, or emit a special event pulse. The special event pulse clears the timer that was selected at the match, so the compare register then acts as a period register for that timer.

Software loads the compare register and the mode field through write strobes and clears the sticky interrupt flag with a clear strobe. The output latch drives a pin whose output enable follows a tristate input. A build option enables a conversion-start output. It fires together with the special event pulse, but only while the converter reports that it is enabled.

A match is registered. All effects of a match become visible on the ports one clock after the clock edge at which the selected timer value first equals the compare register.

Top module: `tmr_cmp_unit`

## Requirements
- R1: When `tmr_sel_i` is 0 the compare register is checked against `tmr_a_i`, and when it is 1 against `tmr_b_i`. A match on the unselected timer has no effect. Match effects appear one clock after the edge at which the values are equal.
- R2: With mode 4'b1000 a match sets `pin_o` to 1. With mode 4'b1001 a match sets `pin_o` to 0.
- R3: With mode 4'b0010 each match inverts `pin_o`.
- R4: In the compare modes 4'b1000, 4'b1001, 4'b0010, 4'b1010 and 4'b1011, every match sets `flag_o` at the same edge as the pin action. Any other mode code causes no pin change, no flag and no event on a match.
- R5: With mode 4'b1010 a match sets `flag_o` and leaves `pin_o` unchanged.
- R6: With mode 4'b1011 a match produces a one-cycle pulse on `evt_o`. In the same cycle it asserts `tmr_a_rst_o` if timer A was selected, or `tmr_b_rst_o` if timer B was selected, and never both.
- R7: `adc_start_o` pulses with `evt_o` only if `adc_en_i` was 1 at the matching edge. Otherwise it stays 0.
- R8: A control write of 4'b0000 forces `pin_o` to 0. It takes priority over a match at the same edge.
- R9: `pin_oe_o` equals `pin_drv_en_i`. The output latch keeps updating while the pin is not driven.
- R10: Detection is on the rising edge of equality. A timer that stays at the compare value causes only one action.
- R11: `flag_o` stays set until `flag_clr_i` clears it. A set and a clear at the same edge leave the flag set.
- R12: After reset, `pin_o`, `flag_o`, `evt_o`, both timer resets and `adc_start_o` are 0, and the mode is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, shared with both timers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmr_a_i | input | 16 | Timer A count |
| tmr_b_i | input | 16 | Timer B count |
| tmr_sel_i | input | 1 | Time base select: 0 picks timer A, 1 picks timer B |
| cmp_wr_i | input | 1 | Compare register write strobe |
| cmp_wdata_i | input | 16 | Compare register write data |
| ctl_wr_i | input | 1 | Mode field write strobe |
| ctl_wdata_i | input | 4 | Mode field write data |
| flag_clr_i | input | 1 | Interrupt flag clear strobe |
| pin_drv_en_i | input | 1 | Tristate control: 1 drives the pin as an output |
| adc_en_i | input | 1 | Converter enabled status |
| pin_o | output | 1 | Compare output latch |
| pin_oe_o | output | 1 | Pin output enable |
| flag_o | output | 1 | Sticky interrupt flag |
| evt_o | output | 1 | Special event pulse |
| tmr_a_rst_o | output | 1 | Synchronous reset request for timer A |
| tmr_b_rst_o | output | 1 | Synchronous reset request for timer B |
| adc_start_o | output | 1 | Conversion start request |

## Verification
A stale equality register shows up as a missing action or a repeated action on the very next matching cycle. A missing action leaves `flag_o` low when it should be set. A repeated action toggles `pin_o` twice or re-sets a flag that was just cleared while the timer holds at the compare value. A corrupted output latch or mode field shows on `pin_o` one clock after the next match or control write. A wrong time base select shows on the wrong timer reset line within one cycle of an event match. The bench compares every output against a behavioural model on every clock, so each such divergence is reported in the cycle it first reaches a port.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam logic [3:0] MODE_OFF = 4'b0000;
  localparam logic [3:0] MODE_SET = 4'b1000;
  localparam logic [3:0] MODE_CLR = 4'b1001;
  localparam logic [3:0] MODE_TGL = 4'b0010;
  localparam logic [3:0] MODE_IRQ = 4'b1010;
  localparam logic [3:0] MODE_EVT = 4'b1011;

  function automatic logic mode_active(input logic [3:0] m);
    return (m == MODE_SET) || (m == MODE_CLR) || (m == MODE_TGL) ||
           (m == MODE_IRQ) || (m == MODE_EVT);
  endfunction
endpackage

// File: rtl/tcu_match_det.sv
module tcu_match_det #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] tmr_a_i,
  input  logic [TW-1:0] tmr_b_i,
  input  logic          sel_i,
  input  logic [TW-1:0] cmp_i,
  output logic          hit_o
);
  logic [TW-1:0] tmr_sel;
  logic          eq, eq_q;

  assign tmr_sel = sel_i ? tmr_b_i : tmr_a_i;
  assign eq      = (tmr_sel == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq;
  end

  // rising edge of equality only
  assign hit_o = eq & ~eq_q;
endmodule

// File: rtl/tcu_out_ctl.sv
module tcu_out_ctl
  import tcu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic [3:0] mode_i,
  input  logic       ctl_zero_i,
  input  logic       flag_clr_i,
  output logic       latch_o,
  output logic       flag_o
);
  logic latch_q, latch_d, flag_q, flag_set;

  assign flag_set = hit_i & mode_active(mode_i);

  always_comb begin
    latch_d = latch_q;
    if (ctl_zero_i) latch_d = 1'b0;
    else if (hit_i) begin
      unique case (mode_i)
        MODE_SET: latch_d = 1'b1;
        MODE_CLR: latch_d = 1'b0;
        MODE_TGL: latch_d = ~latch_q;
        default:  latch_d = latch_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      latch_q <= latch_d;
      if (flag_set)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign latch_o = latch_q;
  assign flag_o  = flag_q;

  // R8
  ctl_zero_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_zero_i |=> !latch_o);
  // R11
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !flag_set) |=> !flag_o);
  // R4
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_set |=> flag_o);
endmodule

// File: rtl/tcu_evt_gen.sv
module tcu_evt_gen
  import tcu_pkg::*;
#(
  parameter bit ADC_TRIG_EN = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic [3:0] mode_i,
  input  logic       sel_i,
  input  logic       adc_en_i,
  output logic       evt_o,
  output logic       tmr_a_rst_o,
  output logic       tmr_b_rst_o,
  output logic       adc_start_o
);
  logic evt_hit, evt_q, evt_sel_q;

  assign evt_hit = hit_i & (mode_i == MODE_EVT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q     <= 1'b0;
      evt_sel_q <= 1'b0;
    end else begin
      evt_q     <= evt_hit;
      evt_sel_q <= sel_i;
    end
  end

  assign evt_o       = evt_q;
  assign tmr_a_rst_o = evt_q & ~evt_sel_q;
  assign tmr_b_rst_o = evt_q & evt_sel_q;

  generate
    if (ADC_TRIG_EN) begin : g_adc
      logic adc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) adc_q <= 1'b0;
        else         adc_q <= evt_hit & adc_en_i;
      end
      assign adc_start_o = adc_q;
    end else begin : g_no_adc
      assign adc_start_o = 1'b0;
    end
  endgenerate

  // R7
  adc_needs_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> evt_o);
  // R6
  one_timer_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tmr_a_rst_o && tmr_b_rst_o));
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
  import tcu_pkg::*;
#(
  parameter int TW          = 16,
  parameter int MW          = 4,
  parameter bit ADC_TRIG_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] tmr_a_i,
  input  logic [TW-1:0] tmr_b_i,
  input  logic          tmr_sel_i,
  input  logic          cmp_wr_i,
  input  logic [TW-1:0] cmp_wdata_i,
  input  logic          ctl_wr_i,
  input  logic [MW-1:0] ctl_wdata_i,
  input  logic          flag_clr_i,
  input  logic          pin_drv_en_i,
  input  logic          adc_en_i,
  output logic          pin_o,
  output logic          pin_oe_o,
  output logic          flag_o,
  output logic          evt_o,
  output logic          tmr_a_rst_o,
  output logic          tmr_b_rst_o,
  output logic          adc_start_o
);
  logic [TW-1:0] cmp_q;
  logic [3:0]    mode_q;
  logic          hit, ctl_zero;

  assign ctl_zero = ctl_wr_i & (ctl_wdata_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      mode_q <= MODE_OFF;
    end else begin
      if (cmp_wr_i) cmp_q  <= cmp_wdata_i;
      if (ctl_wr_i) mode_q <= ctl_wdata_i[3:0];
    end
  end

  tcu_match_det #(.TW(TW)) u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tmr_a_i(tmr_a_i),
    .tmr_b_i(tmr_b_i),
    .sel_i  (tmr_sel_i),
    .cmp_i  (cmp_q),
    .hit_o  (hit)
  );

  tcu_out_ctl u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .mode_i    (mode_q),
    .ctl_zero_i(ctl_zero),
    .flag_clr_i(flag_clr_i),
    .latch_o   (pin_o),
    .flag_o    (flag_o)
  );

  tcu_evt_gen #(.ADC_TRIG_EN(ADC_TRIG_EN)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .mode_i     (mode_q),
    .sel_i      (tmr_sel_i),
    .adc_en_i   (adc_en_i),
    .evt_o      (evt_o),
    .tmr_a_rst_o(tmr_a_rst_o),
    .tmr_b_rst_o(tmr_b_rst_o),
    .adc_start_o(adc_start_o)
  );

  assign pin_oe_o = pin_drv_en_i;

  // R5
  irq_mode_pin_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && mode_q == MODE_IRQ && !ctl_zero) |=> $stable(pin_o));
  // R4
  evt_with_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o) |-> flag_o);
  // R6
  evt_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: tb/tmr_cmp_unit_test.sv
module tmr_cmp_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr_a = '0, tmr_b = '0, cmp_wdata = '0;
  logic        tmr_sel = 1'b0, cmp_wr = 1'b0, ctl_wr = 1'b0, flag_clr = 1'b0;
  logic [3:0]  ctl_wdata = '0;
  logic        drv_en = 1'b1, adc_en = 1'b0;
  logic        pin, oe, flag, evt, arst, brst, adc;

  int errors = 0, checks = 0;
  bit done = 0;

  // behavioural model state
  logic        m_prev_eq = 0, m_latch = 0, m_flag = 0, m_evt = 0, m_arst = 0, m_brst = 0, m_adc = 0;
  logic [15:0] m_cmp = 0;
  logic [3:0]  m_mode = 0;

  always #5 clk = ~clk;

  tmr_cmp_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .tmr_a_i(tmr_a), .tmr_b_i(tmr_b), .tmr_sel_i(tmr_sel),
    .cmp_wr_i(cmp_wr), .cmp_wdata_i(cmp_wdata), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .flag_clr_i(flag_clr), .pin_drv_en_i(drv_en), .adc_en_i(adc_en),
    .pin_o(pin), .pin_oe_o(oe), .flag_o(flag), .evt_o(evt),
    .tmr_a_rst_o(arst), .tmr_b_rst_o(brst), .adc_start_o(adc)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit is_cmp_mode(input logic [3:0] m);
    return m == 4'b1000 || m == 4'b1001 || m == 4'b0010 || m == 4'b1010 || m == 4'b1011;
  endfunction

  task automatic model_step();
    bit eq, hit;
    eq  = ((tmr_sel ? tmr_b : tmr_a) == m_cmp);
    hit = eq && !m_prev_eq;
    if (ctl_wr && ctl_wdata == 4'b0000) m_latch = 0;
    else if (hit) begin
      if (m_mode == 4'b1000) m_latch = 1;
      else if (m_mode == 4'b1001) m_latch = 0;
      else if (m_mode == 4'b0010) m_latch = !m_latch;
    end
    if (hit && is_cmp_mode(m_mode)) m_flag = 1;
    else if (flag_clr) m_flag = 0;
    m_evt  = hit && m_mode == 4'b1011;
    m_arst = m_evt && !tmr_sel;
    m_brst = m_evt && tmr_sel;
    m_adc  = m_evt && adc_en;
    m_prev_eq = eq;
    if (cmp_wr) m_cmp = cmp_wdata;
    if (ctl_wr) m_mode = ctl_wdata;
  endtask

  task automatic compare_all();
    chk("R2 pin model", pin, m_latch);
    chk("R4 flag model", flag, m_flag);
    chk("R6 evt model", evt, m_evt);
    chk("R6 timer A reset model", arst, m_arst);
    chk("R6 timer B reset model", brst, m_brst);
    chk("R7 adc model", adc, m_adc);
    chk("R9 oe model", oe, drv_en);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    cmp_wr = 0; ctl_wr = 0; flag_clr = 0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    ctl_wr = 1; ctl_wdata = m; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R12 reset pin", pin, 0);
    chk("R12 reset flag", flag, 0);
    chk("R12 reset evt", evt, 0);
    chk("R12 reset adc", adc, 0);
    rst_n = 1;
    tmr_a = 16'd50;
    tick();
    // R12: mode off, match at 0 earlier gave nothing
    chk("R12 no flag while mode off", flag, 0);

    cmp_wr = 1; cmp_wdata = 16'd100; tick();
    set_mode(4'b1000);
    // R1: unselected timer matches, no effect
    tmr_b = 16'd100; tick(); tick();
    chk("R1 unselected timer ignored", flag, 0);
    tmr_b = 16'd0;
    tmr_a = 16'd99; tick();
    tmr_a = 16'd100; tick();
    chk("R1 timer A match sets pin", pin, 1);
    chk("R4 flag set on match", flag, 1);
    // R10: hold at compare value, clear flag, no re-set
    flag_clr = 1; tick();
    chk("R11 flag cleared", flag, 0);
    tick(); tick();
    chk("R10 held equality no second flag", flag, 0);
    // R11: clear and set same edge
    tmr_a = 16'd101; tick();
    tmr_a = 16'd100; flag_clr = 1; tick();
    chk("R11 set wins over clear", flag, 1);

    // R2 drive low
    set_mode(4'b1001);
    tmr_a = 16'd101; tick();
    tmr_a = 16'd100; tick();
    chk("R2 drive low", pin, 0);

    // R3 toggle twice, with pin undriven for R9
    set_mode(4'b0010);
    drv_en = 0;
    tmr_a = 16'd101; tick();
    tmr_a = 16'd100; tick();
    chk("R3 toggle to high", pin, 1);
    chk("R9 oe low while latch updates", oe, 0);
    tmr_a = 16'd101; tick();
    tmr_a = 16'd100; tick();
    chk("R3 toggle back low", pin, 0);
    drv_en = 1;
    tmr_a = 16'd101; tick();
    tmr_a = 16'd100; tick();
    chk("R3 toggle high again", pin, 1);

    // R5 irq only
    set_mode(4'b1010);
    flag_clr = 1; tmr_a = 16'd101; tick();
    tmr_a = 16'd100; tick();
    chk("R5 pin unchanged", pin, 1);
    chk("R5 flag set", flag, 1);

    // R4 unused code
    set_mode(4'b0101);
    flag_clr = 1; tmr_a = 16'd101; tick();
    tmr_a = 16'd100; tick();
    chk("R4 unused mode no flag", flag, 0);
    chk("R4 unused mode no pin change", pin, 1);

    // R6/R7 special event on timer B with converter enabled
    set_mode(4'b1011);
    tmr_sel = 1; tmr_b = 16'd99; adc_en = 1; tick();
    tmr_b = 16'd100; tick();
    chk("R6 evt pulse", evt, 1);
    chk("R6 timer B reset", brst, 1);
    chk("R6 timer A not reset", arst, 0);
    chk("R7 adc start", adc, 1);
    tmr_b = 16'd0; tick();
    chk("R6 evt one cycle", evt, 0);
    // R7 converter disabled; timer A event
    tmr_sel = 0; adc_en = 0; tmr_a = 16'd99; tick();
    tmr_a = 16'd100; tick();
    chk("R6 timer A reset", arst, 1);
    chk("R7 adc blocked", adc, 0);
    tmr_a = 16'd0; tick();

    // R8 zero write clears latch even with simultaneous match
    set_mode(4'b1000);
    tmr_a = 16'd100; tick();
    chk("R8 precondition pin high", pin, 1);
    tmr_a = 16'd101; tick();
    tmr_a = 16'd100; ctl_wr = 1; ctl_wdata = 4'b0000; tick();
    chk("R8 zero write wins", pin, 0);
    tmr_a = 16'd101; tick();
    tmr_a = 16'd100; tick();
    chk("R8 mode off after clear", pin, 0);

    // change compare value mid-run
    cmp_wr = 1; cmp_wdata = 16'hFFFF; tick();
    set_mode(4'b1000);
    tmr_a = 16'hFFFF; tick();
    chk("R1 new compare value matches", pin, 1);
    for (int i = 0; i < 20; i++) begin
      tmr_a = 16'(i * 3277);
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule